// File: doc/BRIEF.md
# Input Delay Tap Controller with Eye-Centring Search

This block owns the 6-bit tap setting of an input delay line on a serial receive lane. It runs on the parallel (slow) clock. In manual mode the core steps the tap up or down one position at a time. In automatic mode a training engine sweeps every tap and judges each one from a "sample stable" flag supplied by a comparator on the sampled data. It finds the first and last passing taps, parks the delay line halfway between them so that sampling sits in the middle of the bit, and then raises lock.

The same enable, direction and clear inputs serve both modes. In automatic mode the enable starts training and the clear restarts it. When the lane runs at half rate, training is held off. While lock is high, a debug output shows the settled tap.

Top module: `dpa_tap_ctrl`

## Requirements
- R1: During and straight after reset, `tap` is 0, `locked` is 0 and `dbg_tap` is 0.
- R2: With `mode_sel`=0, an edge where `step_en`=1 and `tap_clr`=0 adds one to `tap` when `step_up`=1 and subtracts one when `step_up`=0.
- R3: In manual mode the tap saturates: stepping up from 63 leaves 63, and stepping down from 0 leaves 0.
- R4: With `mode_sel`=0, `tap_clr`=1 sets `tap` to 0 on the next edge. This takes priority over a step.
- R5: With `mode_sel`=1, `step_up` never moves the tap. A `step_en` pulse starts training only from the idle state. Once locked, `step_en` and `step_up` leave `tap` and `locked` unchanged.
- R6: Training holds each tap for 16 cycles, starting from tap 0. A tap passes only if `sample_ok` is 1 in all 16 of those cycles.
- R7: Lock rises on the 1024th edge after the edge that starts training, never earlier. At that edge `tap` becomes floor((first passing tap + last passing tap)/2).
- R8: `dbg_tap` equals `tap` while `locked`=1 and reads 0 otherwise.
- R9: If no tap passes, `locked` stays 0 and `tap` returns to 0 on the 1024th edge. A new sweep then begins at once, so `tap` is 1 sixteen edges later.
- R10: With `mode_sel`=1 and `half_rate`=0, `tap_clr`=1 restarts training from tap 0 with `locked` cleared. The timing of R7 then counts from that edge.
- R11: With `mode_sel`=1 and `half_rate`=1, no training runs. `locked` goes to 0 and `tap` goes to 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel (slow) clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 0: manual stepping, 1: automatic eye-centring |
| half_rate | input | 1 | 1: lane runs at half rate, which blocks training |
| step_en | input | 1 | Step strobe (manual) or training start (automatic) |
| step_up | input | 1 | Step direction in manual mode: 1 up, 0 down |
| tap_clr | input | 1 | Clears the tap (manual) or restarts training (automatic) |
| sample_ok | input | 1 | Comparator flag: sampled data stable at the current tap |
| tap | output | 6 | Delay tap setting driven to the delay line |
| locked | output | 1 | Training finished with a valid window |
| dbg_tap | output | 6 | Settled tap while locked, 0 otherwise |

## Verification
Manual steps, clears and half-rate aborts appear on `tap` and `locked` one edge after the inputs are sampled. The bench drives inputs at the falling edge and reads the outputs at the next falling edge. Training results follow a fixed schedule counted from the starting edge: the tap first advances on edge 16, lock rises on edge 1024, and a failed sweep shows tap 1 again on edge 1040. The bench counts edges after its start pulse and samples at edges 15, 16, 1023, 1024 and 1040, so an early or late result is caught. The comparator model pulls `sample_ok` low on one phase of a free-running 16-cycle counter, so a marked tap fails only if all 16 dwell cycles are really checked.

// File: rtl/dpa_tap_pkg.sv
package dpa_tap_pkg;

  parameter int TAP_W_DEF = 6;
  parameter int DWELL_DEF = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SWEEP = 2'd1,
    ST_LOCK  = 2'd2
  } dpa_state_e;

  // saturating single step of a tap value
  function automatic logic [TAP_W_DEF-1:0] sat_step(
    input logic [TAP_W_DEF-1:0] cur,
    input logic                 up
  );
    logic [TAP_W_DEF-1:0] top_v;
    top_v = '1;
    if (up) sat_step = (cur == top_v) ? cur : cur + 1'b1;
    else    sat_step = (cur == '0)    ? cur : cur - 1'b1;
  endfunction

  // centre of a window, rounded down, with one extra bit for the sum
  function automatic logic [TAP_W_DEF-1:0] tap_mid(
    input logic [TAP_W_DEF-1:0] lo,
    input logic [TAP_W_DEF-1:0] hi
  );
    logic [TAP_W_DEF:0] sum;
    sum = {1'b0, lo} + {1'b0, hi};
    tap_mid = sum[TAP_W_DEF:1];
  endfunction

endpackage

// File: rtl/dpa_dwell_eval.sv
module dpa_dwell_eval #(
  parameter int DWELL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic sample_ok,
  output logic tap_done,
  output logic tap_pass
);
  localparam int CNT_W = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             acc;

  assign tap_done = run && !restart && (cnt == CNT_LAST);
  assign tap_pass = acc && sample_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= 1'b1;
    end else if (!run || restart || cnt == CNT_LAST) begin
      cnt <= '0;
      acc <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      acc <= acc && sample_ok;
    end
  end
endmodule

// File: rtl/dpa_window_track.sv
module dpa_window_track #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             rec,
  input  logic             pass,
  input  logic [TAP_W-1:0] cur_tap,
  output logic             any_pass,
  output logic [TAP_W-1:0] eff_first,
  output logic [TAP_W-1:0] eff_last
);
  logic             found;
  logic [TAP_W-1:0] first_q;
  logic [TAP_W-1:0] last_q;
  logic             hit;

  assign hit       = rec && pass;
  assign any_pass  = found || hit;
  assign eff_first = found ? first_q : cur_tap;
  assign eff_last  = hit ? cur_tap : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found   <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (clear) begin
      found   <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (hit) begin
      if (!found) first_q <= cur_tap;
      found  <= 1'b1;
      last_q <= cur_tap;
    end
  end
endmodule

// File: rtl/dpa_tap_ctrl.sv
module dpa_tap_ctrl
  import dpa_tap_pkg::*;
#(
  parameter int TAP_W     = TAP_W_DEF,
  parameter int DWELL_CYC = DWELL_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             half_rate,
  input  logic             step_en,
  input  logic             step_up,
  input  logic             tap_clr,
  input  logic             sample_ok,
  output logic [TAP_W-1:0] tap,
  output logic             locked,
  output logic [TAP_W-1:0] dbg_tap
);
  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  dpa_state_e       state;
  logic             training;
  logic             dpa_act;
  logic             restart;
  logic             tap_done;
  logic             tap_pass;
  logic             sweep_end;
  logic             trk_clear;
  logic             any_pass;
  logic [TAP_W-1:0] eff_first;
  logic [TAP_W-1:0] eff_last;

  assign training  = (state == ST_SWEEP);
  assign dpa_act   = mode_sel && !half_rate;
  assign restart   = dpa_act && tap_clr;
  assign sweep_end = training && tap_done && (tap == TAP_MAX);
  assign trk_clear = !training || restart || sweep_end;

  dpa_dwell_eval #(.DWELL_CYC(DWELL_CYC)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (training),
    .restart   (restart),
    .sample_ok (sample_ok),
    .tap_done  (tap_done),
    .tap_pass  (tap_pass)
  );

  dpa_window_track #(.TAP_W(TAP_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (trk_clear),
    .rec       (tap_done),
    .pass      (tap_pass),
    .cur_tap   (tap),
    .any_pass  (any_pass),
    .eff_first (eff_first),
    .eff_last  (eff_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tap    <= '0;
      locked <= 1'b0;
    end else if (!mode_sel) begin
      state  <= ST_IDLE;
      locked <= 1'b0;
      if (tap_clr)      tap <= '0;
      else if (step_en) tap <= sat_step(tap, step_up);
    end else if (half_rate) begin
      state  <= ST_IDLE;
      locked <= 1'b0;
      tap    <= '0;
    end else if (tap_clr) begin
      state  <= ST_SWEEP;
      locked <= 1'b0;
      tap    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (step_en) begin
            state <= ST_SWEEP;
            tap   <= '0;
          end
        end
        ST_SWEEP: begin
          if (tap_done) begin
            if (tap == TAP_MAX) begin
              if (any_pass) begin
                tap    <= tap_mid(eff_first, eff_last);
                locked <= 1'b1;
                state  <= ST_LOCK;
              end else begin
                tap <= '0;
              end
            end else begin
              tap <= tap + 1'b1;
            end
          end
        end
        ST_LOCK: begin
          state <= ST_LOCK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dbg_tap = locked ? tap : '0;

endmodule

// File: rtl/dpa_tap_ctrl_chk.sv
module dpa_tap_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_sel,
  input logic       half_rate,
  input logic       step_en,
  input logic       step_up,
  input logic       tap_clr,
  input logic [5:0] tap,
  input logic       locked,
  input logic       training,
  input logic       tap_done
);
  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && step_en && step_up && !tap_clr && tap != 6'd63) |=> tap == $past(tap) + 6'd1);

  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && step_en && !step_up && !tap_clr && tap != 6'd0) |=> tap == $past(tap) - 6'd1);

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && step_en && !tap_clr &&
     ((step_up && tap == 6'd63) || (!step_up && tap == 6'd0))) |=> $stable(tap));

  p_clr_dyn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && tap_clr) |=> tap == 6'd0);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !half_rate && !tap_clr && locked) |=> (locked && $stable(tap)));

  p_dwell_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !half_rate && !tap_clr && training && !tap_done) |=> $stable(tap));

  p_lock_after_sweep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(tap_done) && $past(tap) == 6'd63));

  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && !half_rate && tap_clr) |=> (!locked && tap == 6'd0 && training));

  p_half_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && half_rate) |=> (!locked && tap == 6'd0 && !training));
endmodule

bind dpa_tap_ctrl dpa_tap_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .half_rate (half_rate),
  .step_en   (step_en),
  .step_up   (step_up),
  .tap_clr   (tap_clr),
  .tap       (tap),
  .locked    (locked),
  .training  (training),
  .tap_done  (tap_done)
);

// File: tb/test_dpa_tap_ctrl.sv
module test_dpa_tap_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       half_rate = 1'b0;
  logic       step_en = 1'b0;
  logic       step_up = 1'b0;
  logic       tap_clr = 1'b0;
  logic       sample_ok;
  logic [5:0] tap;
  logic       locked;
  logic [5:0] dbg_tap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int win_lo = 64;
  int win_hi = 64;
  int win_bad = -1;
  logic [3:0] ph = 4'd0;

  always #2 clk = ~clk;
  always @(posedge clk) ph <= ph + 4'd1;

  assign sample_ok = (int'(tap) >= win_lo) && (int'(tap) <= win_hi) &&
                     !(int'(tap) == win_bad && ph == 4'd5);

  dpa_tap_ctrl i_dpa_tap_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .half_rate(half_rate),
    .step_en(step_en), .step_up(step_up), .tap_clr(tap_clr),
    .sample_ok(sample_ok), .tap(tap), .locked(locked), .dbg_tap(dbg_tap)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input int cur, input bit up);
    int nxt;
    nxt = up ? cur + 1 : cur - 1;
    if (nxt > 63) nxt = 63;
    if (nxt < 0) nxt = 0;
    return nxt;
  endfunction

  function automatic int model_mid(input int lo, input int hi, input int bad);
    int f;
    int l;
    f = (bad == lo) ? lo + 1 : lo;
    l = (bad == hi) ? hi - 1 : hi;
    return (f + l) / 2;
  endfunction

  // one training run; use_clr picks tap_clr instead of step_en as the start
  task automatic run_train(input int lo, input int hi, input int bad,
                           input bit use_clr, input bit exp_lock);
    int exp_tap;
    win_lo = lo; win_hi = hi; win_bad = bad;
    exp_tap = exp_lock ? model_mid(lo, hi, bad) : 0;
    @(negedge clk);
    if (use_clr) tap_clr = 1'b1; else step_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tap_clr = 1'b0; step_en = 1'b0;
    for (int k = 1; k <= 1040; k++) begin
      @(posedge clk);
      @(negedge clk);
      step_up = 1'($urandom);
      step_en = (k < 1020) ? 1'($urandom) : 1'b0;
      if (k == 15) check("R6 tap held through dwell", int'(tap), 0);
      if (k == 16) begin
        check("R6 tap advances after dwell", int'(tap), 1);
        check("R8 dbg zero while unlocked", int'(dbg_tap), 0);
      end
      if (k == 1023) check("R7 no early lock", int'(locked), 0);
      if (k == 1024) begin
        check(exp_lock ? "R7 lock at sweep end" : "R9 no lock without window",
              int'(locked), int'(exp_lock));
        check(exp_lock ? "R7 centre tap" : "R9 tap back to zero", int'(tap), exp_tap);
        check("R8 dbg tap", int'(dbg_tap), exp_lock ? exp_tap : 0);
        if (exp_lock) break;
      end
      if (k == 1040) check("R9 sweep restarts", int'(tap), 1);
    end
    step_en = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int m;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 tap in reset", int'(tap), 0);
    check("R1 locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 tap after reset", int'(tap), 0);
    check("R1 dbg after reset", int'(dbg_tap), 0);

    // manual mode, directed saturation
    step_en = 1'b1; step_up = 1'b1;
    repeat (70) @(posedge clk);
    @(negedge clk);
    check("R3 saturate high", int'(tap), 63);
    step_up = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R2 step down", int'(tap), 58);
    repeat (70) @(posedge clk);
    @(negedge clk);
    check("R3 saturate low", int'(tap), 0);

    // manual mode, random stepping
    m = 0;
    for (int i = 0; i < 400; i++) begin
      step_en = 1'($urandom);
      step_up = ($urandom % 4) != 0;
      tap_clr = ($urandom % 16) == 0;
      if (tap_clr) m = 0;
      else if (step_en) m = model_step(m, step_up);
      @(posedge clk);
      @(negedge clk);
      check(tap_clr ? "R4 clear" : "R2 random step", int'(tap), m);
    end
    step_en = 1'b1; step_up = 1'b1; tap_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R4 clear beats step", int'(tap), 0);
    step_en = 1'b0; tap_clr = 1'b0;

    // automatic mode, half rate blocks training
    mode_sel = 1'b1; half_rate = 1'b1;
    win_lo = 0; win_hi = 63; win_bad = -1;
    step_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    step_en = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R11 half rate tap", int'(tap), 0);
    check("R11 half rate lock", int'(locked), 0);
    half_rate = 1'b0;

    // idle: step_up alone moves nothing
    step_up = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R5 direction ignored in idle", int'(tap), 0);

    run_train(20, 40, -1, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) begin
      step_en = 1'($urandom); step_up = 1'($urandom);
      @(posedge clk);
      @(negedge clk);
    end
    step_en = 1'b0;
    check("R5 locked tap held", int'(tap), 30);
    check("R5 lock held", int'(locked), 1);

    half_rate = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R11 half rate drops lock", int'(locked), 0);
    check("R11 half rate tap", int'(tap), 0);
    half_rate = 1'b0;

    run_train(0, 63, -1, 1'b0, 1'b1);
    run_train(10, 13, 10, 1'b1, 1'b1);
    run_train(63, 63, -1, 1'b1, 1'b1);
    run_train(30, 45, 45, 1'b1, 1'b1);
    run_train(64, 64, -1, 1'b1, 1'b0);

    // restart in the middle of a sweep
    win_lo = 64; win_hi = 64;
    repeat (300) @(posedge clk);
    @(negedge clk);
    run_train(5, 9, -1, 1'b1, 1'b1);
    check("R10 restart lock", int'(locked), 1);

    for (int r = 0; r < 3; r++) begin
      int lo;
      int hi;
      lo = $urandom % 60;
      hi = lo + 2 + ($urandom % (62 - lo));
      run_train(lo, hi, (r == 1) ? lo : -1, 1'b1, 1'b1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule